// File: doc/BRIEF.md
# Multicast Hash Receive Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming multicast frame should be kept. Frame bytes arrive one per cycle on a byte-wide stream with a start-of-frame marker. While the six destination-address bytes stream past, the block folds them into a CRC-32. It then uses the top bits of that CRC to pick one bit of a 64-bit hash table, and it reports an accept or reject decision one cycle after the last address byte.

Software loads the table as two 32-bit words and sets a separate multicast-accept enable. Two single-cycle commands are provided. One wipes both words before a new set of bits is loaded. The other opens the filter to every multicast frame by setting every table bit and the enable together. Frames whose destination is not a group address never pass this filter. Unicast and broadcast matching are handled elsewhere.

Top module: `mhf_filter`

## Requirements
- R1: After reset both table words are zero, the enable is clear and `dec_valid` is low.
- R2: A write with `cfg_wr_en` high stores `cfg_wdata` as follows: `cfg_sel` 2'b00 goes to the low word (table bits 0 to 31) and 2'b01 goes to the high word (table bits 32 to 63). When `cfg_sel[1]` is 1, `cfg_wdata[0]` becomes the multicast-accept enable.
- R3: The table index is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7. The CRC is preset to all ones and is not inverted at the end. It takes the six address bytes in arrival order, each byte least significant bit first, shifting toward the most significant bit. The index is reported on `dec_index`.
- R4: An index below 32 selects bit `index` of the low word. Any other index selects bit `index-32` of the high word.
- R5: `dec_valid` is high for exactly one cycle, the cycle after the sixth address byte is accepted. `dec_index`, `dec_is_mcast` and `dec_accept` hold their values until the next decision.
- R6: A frame is multicast when bit 0 of its first byte is 1, and `dec_is_mcast` reports this. A frame that is not multicast is never accepted.
- R7: While the enable is clear, every frame is rejected, whatever the table holds.
- R8: A `cfg_fill` pulse sets both table words to all ones and sets the enable. It takes priority over `cfg_clear`.
- R9: A `cfg_clear` pulse zeroes both table words. A word write in the same cycle is applied after the clear.
- R10: `rx_sof` with `rx_valid` restarts the address capture on any cycle. Cycles with `rx_valid` low are skipped. Bytes after the sixth, and bytes before the first start of frame, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 00 low word, 01 high word, 1x enable |
| cfg_wdata | input | 32 | Write data |
| cfg_fill | input | 1 | Pulse: all table bits one, enable set |
| cfg_clear | input | 1 | Pulse: both table words cleared |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_is_mcast | output | 1 | Frame destination is a group address |
| dec_accept | output | 1 | Multicast frame accepted |
| dec_index | output | 6 | Hash index of the last decision |

## Verification
A wrong CRC state or a bad byte count shows up as a wrong `dec_index` on the very next decision. A count that stops early or runs late moves the `dec_valid` strobe off the cycle right after the sixth byte. A corrupted table word or enable shows only as a wrong `dec_accept`, and only for frames whose index lands on the damaged bit. The bench therefore sets each computed index bit on purpose as well as using random table contents. Fill, clear and write collisions are each followed at once by frames that read back the affected word.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // Folds one byte, least significant bit first, into a big-endian CRC-32.
    function automatic logic [31:0] crc_fold_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fill,
    input  logic              clear,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_hit,
    output logic              mc_en
);
    localparam int NWORDS = 2;
    localparam int BIT_W  = IDX_W - 1;

    typedef struct packed {
        logic [NWORDS-1:0][WORD_W-1:0] words;
        logic                          en;
    } tbl_t;

    tbl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fill) begin
            st_d.words = '1;
            st_d.en    = 1'b1;
        end else if (clear) begin
            st_d.words = '0;
        end
        if (wr_en) begin
            if (wr_sel[1]) begin
                st_d.en = wr_data[0];
            end else begin
                st_d.words[wr_sel[0]] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NWORDS-1:0] word_hit;
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign word_hit[w] = st_q.words[w][look_idx[BIT_W-1:0]];
    end

    assign look_hit = word_hit[look_idx[IDX_W-1]];
    assign mc_en    = st_q.en;

    assert_fill_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !wr_en) |=> (st_q.words == '1 && st_q.en));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !fill && !wr_en) |=> (st_q.words == '0));

endmodule

// File: rtl/mhf_addr_crc.sv
module mhf_addr_crc #(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_byte,
    output logic        addr_done,
    output logic [31:0] crc_next,
    output logic        mcast_now
);
    import mhf_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

    typedef struct packed {
        logic [31:0]      crc;
        logic [CNT_W-1:0] cnt;
        logic             mcast;
    } cap_t;

    cap_t st_q, st_d;

    logic             take;
    logic [31:0]      crc_base;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        st_d      = st_q;
        crc_base  = rx_sof ? CRC_PRESET : st_q.crc;
        cnt_base  = rx_sof ? '0 : st_q.cnt;
        take      = rx_valid && (rx_sof || (st_q.cnt != '0 && st_q.cnt < LAST));
        mcast_now = rx_sof ? rx_byte[0] : st_q.mcast;
        crc_next  = crc_fold_byte(crc_base, rx_byte);
        addr_done = take && (cnt_base + 1'b1 == LAST);
        if (take) begin
            st_d.crc   = crc_next;
            st_d.cnt   = cnt_base + 1'b1;
            st_d.mcast = mcast_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter #(
    parameter int WORD_W     = 32,
    parameter int ADDR_BYTES = 6,
    localparam int IDX_W = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_fill,
    input  logic              cfg_clear,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_is_mcast,
    output logic              dec_accept,
    output logic [IDX_W-1:0]  dec_index
);
    typedef struct packed {
        logic             valid;
        logic             mcast;
        logic             accept;
        logic [IDX_W-1:0] index;
    } dec_t;

    dec_t dq_q, dq_d;

    logic             addr_done;
    logic [31:0]      crc_next;
    logic             mcast_now;
    logic [IDX_W-1:0] idx_now;
    logic             tbl_hit;
    logic             tbl_en;

    mhf_addr_crc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_byte   (rx_byte),
        .addr_done (addr_done),
        .crc_next  (crc_next),
        .mcast_now (mcast_now)
    );

    assign idx_now = crc_next[31 -: IDX_W];

    mhf_hash_table #(.WORD_W(WORD_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .fill     (cfg_fill),
        .clear    (cfg_clear),
        .look_idx (idx_now),
        .look_hit (tbl_hit),
        .mc_en    (tbl_en)
    );

    always_comb begin
        dq_d       = dq_q;
        dq_d.valid = 1'b0;
        if (addr_done) begin
            dq_d.valid  = 1'b1;
            dq_d.mcast  = mcast_now;
            dq_d.index  = idx_now;
            dq_d.accept = mcast_now && tbl_en && tbl_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else begin
            dq_q <= dq_d;
        end
    end

    assign dec_valid    = dq_q.valid;
    assign dec_is_mcast = dq_q.mcast;
    assign dec_accept   = dq_q.accept;
    assign dec_index    = dq_q.index;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_accept_mcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_is_mcast);

    assert_reject_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> $past(tbl_en));

endmodule

// File: tb/mhf_filter_tb.sv
module mhf_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_fill = 1'b0;
    logic        cfg_clear = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid, dec_is_mcast, dec_accept;
    logic [5:0]  dec_index;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_lo = '0, m_hi = '0;
    logic        m_en = 1'b0;

    always #10 clk = ~clk;

    mhf_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_fill(cfg_fill), .cfg_clear(cfg_clear),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .dec_valid(dec_valid), .dec_is_mcast(dec_is_mcast),
        .dec_accept(dec_accept), .dec_index(dec_index)
    );

    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [7:0]  b;
        for (int k = 0; k < 6; k++) begin
            b = a[47 - 8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                if (c[31] != b[j]) c = (c << 1) ^ 32'h04C11DB7;
                else c = c << 1;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic [5:0] ix = ref_index(a);
        logic bitv = (ix < 6'd32) ? m_lo[ix[4:0]] : m_hi[ix - 6'd32];
        return a[40] && m_en && bitv;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic fill, input logic clr, input logic wr,
                       input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_fill = fill; cfg_clear = clr; cfg_wr_en = wr; cfg_sel = sel; cfg_wdata = d;
        if (fill) begin m_lo = '1; m_hi = '1; m_en = 1'b1; end
        else if (clr) begin m_lo = '0; m_hi = '0; end
        if (wr) begin
            if (sel[1]) m_en = d[0];
            else if (sel[0]) m_hi = d;
            else m_lo = d;
        end
        @(negedge clk);
        cfg_fill = 0; cfg_clear = 0; cfg_wr_en = 0;
    endtask

    // Sends an address, optional gaps and trailing bytes, then checks the decision.
    task automatic frame(input logic [47:0] a, input bit gaps, input int extra, input string req);
        logic [5:0] eix = ref_index(a);
        logic       eac = ref_accept(a);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (k == 0); rx_byte = a[47 - 8*k -: 8];
            if (gaps && k != 5) begin
                @(negedge clk);
                rx_valid = 0; rx_sof = 0; rx_byte = 8'h5A;
                chk(dec_valid == 0, "R10 gap", dec_valid, 0);
            end
        end
        @(negedge clk);
        rx_sof = 0;
        if (extra > 0) begin rx_valid = 1; rx_byte = 8'hC3; end
        else rx_valid = 0;
        chk(dec_valid == 1, {req, " R5 strobe"}, dec_valid, 1);
        chk(dec_index == eix, {req, " R3 index"}, dec_index, eix);
        chk(dec_is_mcast == a[40], {req, " R6 mcast"}, dec_is_mcast, a[40]);
        chk(dec_accept == eac, {req, " R4 accept"}, dec_accept, eac);
        for (int e = 1; e <= extra; e++) begin
            @(negedge clk);
            rx_valid = (e < extra); rx_byte = 8'(e * 37);
            chk(dec_valid == 0 && dec_index == eix, "R10 extra bytes", dec_index, eix);
        end
        @(negedge clk);
        rx_valid = 0;
        chk(dec_valid == 0 && dec_accept == eac, "R5 hold", dec_accept, eac);
    endtask

    // Sets the exact table bit for an address, then checks it hits.
    task automatic targeted(input logic [47:0] a);
        logic [5:0] ix = ref_index(a);
        cfg(0, 1, 0, 2'b00, 0);
        if (ix < 32) cfg(0, 0, 1, 2'b00, 32'h1 << ix[4:0]);
        else cfg(0, 0, 1, 2'b01, 32'h1 << (ix - 32));
        frame(a, 0, 0, "R4 targeted");
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(dec_valid == 0 && dec_accept == 0, "R1 reset outputs", dec_valid, 0);

        // R1: table empty after reset, so enabling shows all misses
        cfg(0, 0, 1, 2'b10, 1);
        frame(48'h01005E000001, 0, 0, "R1 empty table");

        // R2/R4: targeted hits on low and high words
        for (int i = 0; i < 24; i++) begin
            a = {16'($urandom), 32'($urandom)};
            a[40] = 1'b1;
            targeted(a);
        end

        // R6: non-multicast never accepted even with all bits set
        cfg(1, 0, 0, 2'b00, 0);
        frame(48'h001122334455, 0, 0, "R6 unicast");
        frame(48'h0180C2000000, 0, 0, "R8 fill accept");

        // R7: disable rejects despite full table
        cfg(0, 0, 1, 2'b10, 0);
        frame(48'h0180C2000000, 0, 0, "R7 disabled");
        chk(dec_accept == 0, "R7 reject", dec_accept, 0);

        // R8 over R9: fill wins when both pulse
        cfg(0, 1, 0, 2'b00, 0);
        cfg(1, 1, 0, 2'b00, 0);
        frame(48'h3300000000FF, 0, 0, "R8 priority");

        // R9: clear with same-cycle write into high word
        cfg(0, 1, 1, 2'b01, 32'hFFFF_FFFF);
        for (int i = 0; i < 12; i++) begin
            a = {16'($urandom), 32'($urandom)};
            a[40] = 1'b1;
            frame(a, 0, 0, "R9 clear+write");
        end

        // R10: restart mid-address, gaps, trailing bytes, stray bytes before sof
        @(negedge clk);
        rx_valid = 1; rx_sof = 0; rx_byte = 8'hFF;
        @(negedge clk);
        rx_sof = 1; rx_byte = 8'h77;
        @(negedge clk);
        rx_sof = 0; rx_byte = 8'h88;
        frame(48'h01005E7F0102, 1, 0, "R10 restart+gaps");
        frame(48'h01005E7F0102, 0, 5, "R10 trailing");

        // Random tables and addresses
        for (int i = 0; i < 150; i++) begin
            if (i % 10 == 0) begin
                cfg(0, 1, 0, 2'b00, 0);
                cfg(0, 0, 1, 2'b00, $urandom);
                cfg(0, 0, 1, 2'b01, $urandom);
                cfg(0, 0, 1, 2'b10, 32'($urandom_range(0, 3) != 0));
            end
            a = {16'($urandom), 32'($urandom)};
            frame(a, ($urandom_range(0, 3) == 0), $urandom_range(0, 2), "R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule